// File: doc/BRIEF.md
# Paged Register-Access SPI Slave

This block is a 4-wire SPI slave that lets a host reach a 16-bit register address space while spending only one address byte per transaction. Every frame opens with a command byte. Its top bit picks the direction, and its low seven bits give an offset inside the current page. A separately stored 9-bit page value supplies the upper address bits. A reserved command offset makes the frame address the page value itself instead of a data register. The host sets a new page with one short write frame, then issues any number of cheap single-offset accesses inside that page.

The serial pins are oversampled in a fast system clock domain. Each pin passes through a synchronizer, and edges of the serial clock are detected there. The link runs in SPI mode 0, most significant bit first, and is full duplex. On reads, the byte clocked out during the command byte is a dummy, and register data follows on the next byte. After the first data byte, further bytes in the same frame step the offset, so a frame can read or write a burst of registers. A small internal byte array, placed at a parameterised base address, stands in for the device registers.

Top module: `spi_paged_regs`

## Requirements
- R1: SPI mode 0, MSB first, full duplex. MOSI is sampled on rising SCLK edges and MISO moves on falling edges. For each byte shifted in, exactly one byte is shifted out, and the MSB of a loaded byte is on MISO before the first rising edge of that byte.
- R2: In the command byte, bit 7 = 1 means read and bit 7 = 0 means write.
- R3: The access address is {page[8:0], offset[6:0]}, where the offset is bits 6..0 of the command byte.
- R4: Command offset 0x7C with a write loads the page. Data byte 0 bit 7 goes to page bit 0 (address bit 7). Data byte 1 goes to page bits 8..1 (address bits 15..8). Any later bytes are ignored. For example, 7C 00 C0 gives page base 0xC000.
- R5: During a read, the byte returned while the command byte shifts in is 0x00. The addressed data comes back on the next byte. Every byte returned during a write frame is 0x00.
- R6: The page resets to 0 and keeps its value across frames until it is rewritten.
- R7: Each data byte after the first uses the previous offset plus one. The offset wraps from 0x7F to 0x00 and stays in the same page.
- R8: A high CS drops any partial byte, and the next byte after CS goes low is a command byte. MISO is 0 while CS is high.
- R9: The register array holds DEPTH bytes starting at BASE (default 64 at 0xC000). Entry i resets to (3*i + 0x11) mod 256. Reads outside the array return 0x00, and writes outside it change nothing.
- R10: A read with command offset 0x7C returns {page[0], 7'b0}, then page[8:1], then 0x00 for every later byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host; 0 when not selected |

## Verification
Reads at page 0 and at page 0xC000 are compared against the reset pattern. A hit is only possible if the offset is combined with the stored page. A write followed by a read-back tells the direction bit apart from the offset bits. A burst that crosses offset 0x7F lands on entry 0 of the same page, and a non-zero value there separates wrapping from carrying into the page. Two page values are written and read back: one with the odd address bit 7 set, and one with a trailing extra byte. These show the byte order of the page load and that extra bytes are ignored. A frame cut after three bits, and a read dropped mid-byte, show that CS resets the frame and silences MISO.

// File: rtl/spi_paged_regs.sv
module spi_paged_regs #(
  parameter int              DEPTH       = 64,
  parameter logic [15:0]     BASE        = 16'hC000,
  parameter int              SYNC_STAGES = 2,
  parameter logic [6:0]      PAGE_OFFSET = 7'h7C,
  parameter int              INIT_MUL    = 3,
  parameter int              INIT_ADD    = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  localparam int          IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [15:0] DEPTH_A = 16'(DEPTH);

  logic [SYNC_STAGES-1:0] sclk_q, cs_q, mosi_q;
  logic                   sclk_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk};
      cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
      mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
      sclk_d <= sclk_q[SYNC_STAGES-1];
    end

  wire sclk_s    = sclk_q[SYNC_STAGES-1];
  wire cs_idle   = cs_q[SYNC_STAGES-1];
  wire mosi_s    = mosi_q[SYNC_STAGES-1];
  wire sclk_rise = sclk_s & ~sclk_d & ~cs_idle;
  wire sclk_fall = ~sclk_s & sclk_d & ~cs_idle;

  logic [2:0]  bit_cnt;
  logic [6:0]  rx_sh;
  logic        first, is_rd, pg_mode;
  logic [1:0]  idx;
  logic [6:0]  off;
  logic [8:0]  page;
  logic [7:0]  tx_sh;
  logic [7:0]  mem [DEPTH];

  wire       byte_done = sclk_rise && (bit_cnt == 3'd7);
  wire [7:0] rx_byte   = {rx_sh, mosi_s};

  function automatic logic in_array(input logic [15:0] a);
    return (a >= BASE) && ((a - BASE) < DEPTH_A);
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(input logic [15:0] a);
    logic [15:0] rel;
    rel = a - BASE;
    return rel[IDX_W-1:0];
  endfunction

  wire [6:0]  nxt_off  = first ? rx_byte[6:0] : off + 7'd1;
  wire        nxt_pg   = first ? (rx_byte[6:0] == PAGE_OFFSET) : pg_mode;
  wire        nxt_rd   = first ? rx_byte[7] : is_rd;
  wire [1:0]  nxt_idx  = first ? 2'd0 : ((idx == 2'd2) ? 2'd2 : idx + 2'd1);
  wire [15:0] look_a   = {page, nxt_off};
  wire [15:0] cur_a    = {page, off};

  logic [7:0] look_data, pg_data, tx_next;
  always_comb begin
    look_data = in_array(look_a) ? mem[to_idx(look_a)] : 8'h00;
    case (nxt_idx)
      2'd0:    pg_data = {page[0], 7'b0};
      2'd1:    pg_data = page[8:1];
      default: pg_data = 8'h00;
    endcase
    tx_next = nxt_rd ? (nxt_pg ? pg_data : look_data) : 8'h00;
  end

  wire data_wr = byte_done && !first && !is_rd;
  wire mem_wr  = data_wr && !pg_mode && in_array(cur_a);
  wire page_wr = data_wr && pg_mode;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      first   <= 1'b1;
      is_rd   <= 1'b0;
      pg_mode <= 1'b0;
      idx     <= '0;
      off     <= '0;
      tx_sh   <= '0;
    end else if (cs_idle) begin
      bit_cnt <= '0;
      first   <= 1'b1;
      tx_sh   <= '0;
    end else begin
      if (sclk_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sh   <= rx_byte[6:0];
      end
      if (byte_done) begin
        first   <= 1'b0;
        is_rd   <= nxt_rd;
        pg_mode <= nxt_pg;
        idx     <= nxt_idx;
        off     <= nxt_off;
        tx_sh   <= tx_next;
      end else if (sclk_fall && bit_cnt != 3'd0) begin
        tx_sh   <= {tx_sh[6:0], 1'b0};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      page <= '0;
    else if (page_wr) begin
      if (idx == 2'd0)      page[0]   <= rx_byte[7];
      else if (idx == 2'd1) page[8:1] <= rx_byte;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i * INIT_MUL + INIT_ADD);
    end else if (mem_wr) begin
      mem[to_idx(cur_a)] <= rx_byte;
    end

  assign miso = tx_sh[7] & ~cs_idle;

  // R8: a deselected frame restarts at a command byte with a silent MISO
  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (bit_cnt == 3'd0 && first && !miso));

  // R4/R6: page moves only on a data byte of a page write frame
  assert_page_only_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(page) |-> $past(byte_done && !first && !is_rd && pg_mode));

  // R7: the offset only advances on a byte boundary
  assert_offset_on_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(off) |-> $past(byte_done));

  // R1: outgoing shift register holds between falling edges and loads
  assert_tx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_idle && !sclk_fall && !byte_done) |=> $stable(tx_sh));

  // R1: every eighth rising edge closes a byte
  assert_byte_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (bit_cnt == 3'd0));

  // R2: the command byte is consumed once per frame
  assert_cmd_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && first && !cs_idle) |=> !first);
endmodule

// File: tb/spi_paged_regs_test.sv
module spi_paged_regs_test;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int checks = 0, errors = 0;
  logic [7:0] txb [6];
  logic [7:0] rxb [6];

  always #2 clk = ~clk;

  spi_paged_regs uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
                      .mosi(mosi), .miso(miso));

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 3 + 17);
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    for (int b = 7; b >= 0; b--) begin
      mosi = t[b];
      wait_clk(H);
      r[b] = miso;
      sclk = 1'b1;
      wait_clk(H);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input int n);
    cs_n = 1'b0;
    wait_clk(H);
    for (int k = 0; k < n; k++) xfer(txb[k], rxb[k]);
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(2 * H);
  endtask

  task automatic f2(input logic [7:0] a, input logic [7:0] b);
    txb[0] = a; txb[1] = b; frame(2);
  endtask

  task automatic f3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    txb[0] = a; txb[1] = b; txb[2] = c; frame(3);
  endtask

  task automatic f4(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                    input logic [7:0] d);
    txb[0] = a; txb[1] = b; txb[2] = c; txb[3] = d; frame(4);
  endtask

  task automatic t_reset;
    chk({7'b0, miso}, 8'h00, "R8 miso idle after reset");
    f3(8'hFC, 8'h00, 8'h00);
    chk(rxb[1], 8'h00, "R6 page low byte at reset");
    chk(rxb[2], 8'h00, "R6 page high byte at reset");
    f2(8'hA4, 8'h00);
    chk(rxb[1], 8'h00, "R9 read outside array");
    f2(8'h24, 8'h99);
  endtask

  task automatic t_page_set;
    f3(8'h7C, 8'h00, 8'hC0);
    f2(8'hA4, 8'h00);
    chk(rxb[0], 8'h00, "R5 dummy byte during command");
    chk(rxb[1], init_val(8'h24), "R3 R9 read 0xC024 reset pattern");
    f4(8'hFC, 8'h00, 8'h00, 8'h00);
    chk(rxb[1], 8'h00, "R10 page byte 0");
    chk(rxb[2], 8'hC0, "R10 page byte 1");
    chk(rxb[3], 8'h00, "R10 page trailing byte");
  endtask

  task automatic t_write_read;
    f2(8'h05, 8'h5A);
    chk(rxb[1], 8'h00, "R5 write frame returns zero");
    f2(8'h85, 8'h00);
    chk(rxb[1], 8'h5A, "R2 write then read back");
    f2(8'h86, 8'h00);
    chk(rxb[1], init_val(6), "R2 neighbour untouched");
  endtask

  task automatic t_burst;
    f4(8'h10, 8'hA1, 8'hA2, 8'hA3);
    txb[0] = 8'h90; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00; txb[4] = 8'h00;
    frame(5);
    chk(rxb[1], 8'hA1, "R7 burst byte 0");
    chk(rxb[2], 8'hA2, "R7 burst byte 1");
    chk(rxb[3], 8'hA3, "R7 burst byte 2");
    chk(rxb[4], init_val(8'h13), "R7 burst byte 3");
  endtask

  task automatic t_wrap;
    f3(8'hFF, 8'h00, 8'h00);
    chk(rxb[1], 8'h00, "R7 offset 0x7F outside array");
    chk(rxb[2], init_val(0), "R7 wrap to offset 0 same page");
  endtask

  task automatic t_page_odd;
    f3(8'h7C, 8'h80, 8'hC0);
    f2(8'hA4, 8'h00);
    chk(rxb[1], 8'h00, "R3 odd page moves out of array");
    f3(8'hFC, 8'h00, 8'h00);
    chk(rxb[1], 8'h80, "R4 page bit 0 from byte 0 bit 7");
    chk(rxb[2], 8'hC0, "R4 page upper from byte 1");
    f4(8'h7C, 8'h00, 8'hC0, 8'hFF);
    f4(8'hFC, 8'h00, 8'h00, 8'h00);
    chk(rxb[1], 8'h00, "R4 extra byte ignored low");
    chk(rxb[2], 8'hC0, "R4 extra byte ignored high");
    f2(8'hA4, 8'h00);
    chk(rxb[1], init_val(8'h24), "R6 page persists across frames");
  endtask

  task automatic t_abort;
    logic [7:0] dummy;
    cs_n = 1'b0;
    wait_clk(H);
    for (int b = 0; b < 3; b++) begin
      mosi = 1'b1; wait_clk(H); sclk = 1'b1; wait_clk(H); sclk = 1'b0;
    end
    cs_n = 1'b1;
    wait_clk(2 * H);
    f2(8'h07, 8'h66);
    f2(8'h87, 8'h00);
    chk(rxb[1], 8'h66, "R8 partial byte dropped");
    cs_n = 1'b0;
    wait_clk(H);
    xfer(8'h90, dummy);
    wait_clk(H);
    chk({7'b0, miso}, 8'h01, "R1 data MSB ready before next byte");
    cs_n = 1'b1;
    wait_clk(6);
    chk({7'b0, miso}, 8'h00, "R8 miso low after deselect");
    wait_clk(2 * H);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset;
    t_page_set;
    t_write_read;
    t_burst;
    t_wrap;
    t_page_odd;
    t_abort;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule